// File: doc/BRIEF.md
# Dual-strobe up/down preset counter

This block is a 4-bit counter that steps on two separate strobe inputs instead of one clock plus a direction bit. A rising edge on the up strobe adds one to the count, and a rising edge on the down strobe takes one away. A free-running system clock samples both strobes through a two-flop synchroniser and then finds their rising edges. An edge counts only while the other strobe rests high. If both strobes rise in the same sample, the two edges cancel.

The count can be set to a value through a parallel data input with an active-low load. An active-high clear sends the count to zero at once, without waiting for a clock. Both act whatever the strobes are doing.

A parameter picks decade operation (0 to 9) or binary operation (0 to 15). Two active-low terminal outputs make a chain of stages possible: carry_n of one stage drives the up strobe of the next, and borrow_n drives its down strobe. Each output is low only while the count sits at its end value and the matching strobe is low. It therefore rises together with the strobe edge that wraps the count. Every input is a plain level, so there is no handshake and no back-pressure.

Top module: `updn_preset_counter`

## Requirements
- R1: A rising edge on up_strobe while down_strobe is high adds one to count. With no counting edge, no load and no clear, count holds its value.
- R2: A rising edge on down_strobe while up_strobe is high takes one from count.
- R3: Some strobe edges are ignored and leave count unchanged:
  - an edge on one strobe while the other strobe is low;
  - rising edges on both strobes in the same sample.
- R4: When load_n is low at a rising clk edge, count takes data_in on that edge. Strobe edges seen while load_n is low are discarded.
- R5: clear high forces count to 0 at once, without a clock edge. Clear overrides both load and the strobes. After clear, carry_n and borrow_n are both 1.
- R6: The count wraps at its end values:
  - decade mode (DECADE=1): up from 9 gives 0, and down from 0 gives 9;
  - binary mode (DECADE=0): up from 15 gives 0, and down from 0 gives 15.
- R7: carry_n is 0 exactly while count is at its maximum (9 or 15) and the synchronised up strobe is low. borrow_n is 0 exactly while count is 0 and the synchronised down strobe is low. Otherwise both are 1.
- R8: In decade mode, a loaded value from 10 to 15 steps up to 0 without driving carry_n low, and steps down to the value minus one.
- R9: count changes on the third rising clk edge after a strobe's rising transition.
- R10: A decade stage whose up and down strobes are fed by another stage's carry_n and borrow_n steps once on each wrap of that stage, in the direction of the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes and load |
| up_strobe | input | 1 | Count-up strobe; a rising edge counts |
| down_strobe | input | 1 | Count-down strobe; a rising edge counts |
| load_n | input | 1 | Active-low synchronous preset |
| clear | input | 1 | Active-high asynchronous clear |
| data_in | input | WIDTH | Preset value |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low overflow pulse for chaining |
| borrow_n | output | 1 | Active-low underflow pulse for chaining |

## Verification
The bench walks preset-and-step sequences through a decade and a binary instance side by side, so that the wrap at 9 and the wrap at 15 are both checked. A second decade stage fed by the first stage's terminal outputs shows whether carry and borrow pulses arrive, and in the right direction. A design with a mistimed terminal pulse would leave that stage off by one.

Directed cases cover several faults:
- a design that decodes edges without looking at the other strobe's level would count when it should not;
- letting simultaneous edges through would step the count;
- a design that queues an edge during a load would step after the load releases;
- a design with a synchronous clear would show a stale count before the next clock.

In decade mode the bench preloads 13 and 15 and expects a silent step to 0. A design that wraps invalid values through 9 would fire a carry and step the chained stage. The bench also counts the exact clock edges from a strobe edge to the count change, which exposes a missing or extra pipeline stage.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_t;
endpackage

// File: rtl/updn_strobe_sync.sv
module updn_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clear,
  input  logic strobe,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or posedge clear) begin
    if (clear) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], strobe};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
endmodule

// File: rtl/updn_step_decode.sv
module updn_step_decode
  import updn_pkg::*;
(
  input  logic  up_level,
  input  logic  up_rise,
  input  logic  dn_level,
  input  logic  dn_rise,
  output step_t step
);
  logic up_ok;
  logic dn_ok;

  assign up_ok = up_rise & dn_level;
  assign dn_ok = dn_rise & up_level;

  always_comb begin
    step = STEP_HOLD;
    if (up_ok && !dn_ok) step = STEP_UP;
    else if (dn_ok && !up_ok) step = STEP_DOWN;
  end
endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
  import updn_pkg::*;
#(
  parameter int               WIDTH   = 4,
  parameter logic [WIDTH-1:0] CNT_MAX = WIDTH'(9)
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             load_n,
  input  logic [WIDTH-1:0] data_in,
  input  step_t            step,
  output logic [WIDTH-1:0] count
);
  logic [WIDTH-1:0] nxt;

  always_comb begin
    nxt = count;
    if (!load_n) nxt = data_in;
    else if (step == STEP_UP) nxt = (count >= CNT_MAX) ? '0 : count + WIDTH'(1);
    else if (step == STEP_DOWN) nxt = (count == '0) ? CNT_MAX : count - WIDTH'(1);
  end

  always_ff @(posedge clk or posedge clear) begin
    if (clear) count <= '0;
    else count <= nxt;
  end

  // R4
  load_take_chk: assert property (@(posedge clk) disable iff (clear)
    !load_n |=> count == $past(data_in));

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (clear)
    (load_n && step == STEP_HOLD) |=> $stable(count));

  // R6
  up_wrap_chk: assert property (@(posedge clk) disable iff (clear)
    (load_n && step == STEP_UP && count == CNT_MAX) |=> count == '0);

  // R6
  down_wrap_chk: assert property (@(posedge clk) disable iff (clear)
    (load_n && step == STEP_DOWN && count == '0) |=> count == CNT_MAX);

  // R8
  invalid_up_chk: assert property (@(posedge clk) disable iff (clear)
    (load_n && step == STEP_UP && count > CNT_MAX) |=> count == '0);
endmodule

// File: rtl/updn_term_flags.sv
module updn_term_flags #(
  parameter int               WIDTH   = 4,
  parameter logic [WIDTH-1:0] CNT_MAX = WIDTH'(9)
) (
  input  logic [WIDTH-1:0] count,
  input  logic             up_level,
  input  logic             dn_level,
  output logic             carry_n,
  output logic             borrow_n
);
  assign carry_n  = ~((count == CNT_MAX) & ~up_level);
  assign borrow_n = ~((count == '0) & ~dn_level);
endmodule

// File: rtl/updn_preset_counter.sv
module updn_preset_counter
  import updn_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit DECADE      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             up_strobe,
  input  logic             down_strobe,
  input  logic             load_n,
  input  logic             clear,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] CNT_MAX = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  logic [1:0] strobe_in;
  logic [1:0] lvl;
  logic [1:0] rise;
  step_t      step;

  assign strobe_in = {down_strobe, up_strobe};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    updn_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .clear  (clear),
      .strobe (strobe_in[g]),
      .level  (lvl[g]),
      .rise   (rise[g])
    );
  end

  updn_step_decode u_decode (
    .up_level (lvl[0]),
    .up_rise  (rise[0]),
    .dn_level (lvl[1]),
    .dn_rise  (rise[1]),
    .step     (step)
  );

  updn_count_core #(.WIDTH(WIDTH), .CNT_MAX(CNT_MAX)) u_core (
    .clk     (clk),
    .clear   (clear),
    .load_n  (load_n),
    .data_in (data_in),
    .step    (step),
    .count   (count)
  );

  updn_term_flags #(.WIDTH(WIDTH), .CNT_MAX(CNT_MAX)) u_flags (
    .count    (count),
    .up_level (lvl[0]),
    .dn_level (lvl[1]),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
  );

  // R7
  carry_rise_wrap_chk: assert property (@(posedge clk) disable iff (clear)
    ($rose(carry_n) && $past(load_n) && load_n && lvl[1] && !rise[1]) |=> count == '0);
endmodule

// File: tb/updn_preset_counter_tb.sv
module updn_preset_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;

  // {op, data, expected decade, expected binary, expected chained stage}
  // op: 1 = load, 2 = up step, 3 = down step
  localparam logic [19:0] VEC [NVEC] = '{
    20'h17770, 20'h20880, 20'h20990, 20'h200A1, 20'h201B1, 20'h202C1,
    20'h301B1, 20'h300A1, 20'h30990, 20'h30880, 20'h30770,
    20'h1DDD0, 20'h200E0, 20'h201F0, 20'h20200, 20'h20310, 20'h20420,
    20'h30310, 20'h30200, 20'h301F0, 20'h300E0, 20'h309D9,
    20'h1CCC9, 20'h30BB9, 20'h1FFF9, 20'h20009
  };

  logic       clk = 1'b0;
  logic       up = 1'b1;
  logic       dn = 1'b1;
  logic       load_n = 1'b1;
  logic       clear = 1'b1;
  logic [3:0] data = 4'd0;
  logic [3:0] cnt_dec, cnt_bin, cnt_hi;
  logic       carry_dec, borrow_dec, carry_bin, borrow_bin, carry_hi, borrow_hi;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  updn_preset_counter #(.DECADE(1'b1)) u_dut (
    .clk(clk), .up_strobe(up), .down_strobe(dn), .load_n(load_n), .clear(clear),
    .data_in(data), .count(cnt_dec), .carry_n(carry_dec), .borrow_n(borrow_dec));

  updn_preset_counter #(.DECADE(1'b0)) u_bin (
    .clk(clk), .up_strobe(up), .down_strobe(dn), .load_n(load_n), .clear(clear),
    .data_in(data), .count(cnt_bin), .carry_n(carry_bin), .borrow_n(borrow_bin));

  updn_preset_counter #(.DECADE(1'b1)) u_hi (
    .clk(clk), .up_strobe(carry_dec), .down_strobe(borrow_dec), .load_n(1'b1),
    .clear(clear), .data_in(4'd0), .count(cnt_hi), .carry_n(carry_hi),
    .borrow_n(borrow_hi));

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_load(input logic [3:0] d);
    data = d;
    load_n = 1'b0;
    tick(1);
    load_n = 1'b1;
    tick(1);
  endtask

  task automatic do_up();
    up = 1'b0;
    tick(4);
    up = 1'b1;
    tick(8);
  endtask

  task automatic do_dn();
    dn = 1'b0;
    tick(4);
    dn = 1'b1;
    tick(8);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    clear = 1'b0;
    tick(1);
    check("R5 reset count", cnt_dec, 4'd0);
    check("R5 reset carry_n", {3'b0, carry_dec}, 4'd1);
    check("R5 reset borrow_n", {3'b0, borrow_dec}, 4'd1);

    // R1 R2 R6 R8 R10 vector walk
    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][19:16])
        4'h1: do_load(VEC[i][15:12]);
        4'h2: do_up();
        default: do_dn();
      endcase
      check($sformatf("R1/R2/R6/R8 decade vec %0d", i), cnt_dec, VEC[i][11:8]);
      check($sformatf("R6 binary vec %0d", i), cnt_bin, VEC[i][7:4]);
      check($sformatf("R10 chained vec %0d", i), cnt_hi, VEC[i][3:0]);
    end

    // R9 latency: two edges later still old, third edge new
    do_load(4'd4);
    up = 1'b0;
    tick(4);
    up = 1'b1;
    tick(2);
    check("R9 before third edge", cnt_dec, 4'd4);
    tick(1);
    check("R9 at third edge", cnt_dec, 4'd5);
    tick(6);

    // R7 terminal outputs
    do_load(4'd9);
    up = 1'b0;
    tick(3);
    check("R7 carry_n low at 9", {3'b0, carry_dec}, 4'd0);
    check("R7 binary carry_n high at 9", {3'b0, carry_bin}, 4'd1);
    up = 1'b1;
    tick(3);
    check("R7 carry_n high after wrap", {3'b0, carry_dec}, 4'd1);
    check("R6 wrap 9 to 0", cnt_dec, 4'd0);
    tick(6);
    do_load(4'd0);
    dn = 1'b0;
    tick(3);
    check("R7 borrow_n low at 0", {3'b0, borrow_dec}, 4'd0);
    check("R7 binary borrow_n low at 0", {3'b0, borrow_bin}, 4'd0);
    check("R7 carry_n high at 0", {3'b0, carry_dec}, 4'd1);
    dn = 1'b1;
    tick(3);
    check("R6 decade down wrap", cnt_dec, 4'd9);
    check("R6 binary down wrap", cnt_bin, 4'd15);
    tick(6);

    // R3 edges with the other strobe low, and coincident edges
    do_load(4'd5);
    dn = 1'b0;
    tick(4);
    do_up();
    check("R3 up edge while down low", cnt_dec, 4'd5);
    up = 1'b0;
    tick(4);
    dn = 1'b1;
    tick(4);
    check("R3 down edge while up low", cnt_dec, 4'd5);
    up = 1'b1;
    tick(4);
    check("R1 up edge counts", cnt_dec, 4'd6);
    up = 1'b0;
    dn = 1'b0;
    tick(4);
    up = 1'b1;
    dn = 1'b1;
    tick(6);
    check("R3 coincident edges cancel", cnt_dec, 4'd6);

    // R4 load held across a strobe edge
    data = 4'd8;
    load_n = 1'b0;
    tick(1);
    up = 1'b0;
    tick(4);
    up = 1'b1;
    tick(4);
    check("R4 load holds over edge", cnt_dec, 4'd8);
    load_n = 1'b1;
    tick(4);
    check("R4 edge not queued", cnt_dec, 4'd8);

    // R5 asynchronous clear overriding load
    do_load(4'd5);
    @(posedge clk);
    #(CLK_PERIOD/4);
    clear = 1'b1;
    #1;
    check("R5 clear acts without clock", cnt_dec, 4'd0);
    @(negedge clk);
    data = 4'd7;
    load_n = 1'b0;
    tick(2);
    check("R5 clear over load", cnt_dec, 4'd0);
    clear = 1'b0;
    load_n = 1'b1;
    tick(2);
    check("R5 after clear release", cnt_dec, 4'd0);

    finish_run();
  end
endmodule